// File: doc/BRIEF.md
# Early-In Sequential Divider

This block divides one unsigned integer by another, one quotient bit per clock, with a restoring shift-and-subtract loop. Before the loop starts it spends a single cycle finding the most significant set bit of the dividend and shifts the leading zeros out. The loop then only runs over the significant bits, so a small dividend finishes in only a few cycles.

A caller drives the operands and pulses `start` while the block is idle. `busy` stays high while the division runs. `done` pulses for one cycle when the quotient and remainder are ready, and both results stay unchanged until the next accepted start. A zero divisor does not run the loop. It returns a fixed result and raises a flag.

Top module: `earlyin_div`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero`, `quotient` and `remainder` are all zero.
- R2: For a nonzero divisor, `quotient` equals dividend / divisor and `remainder` equals dividend mod divisor, both unsigned.
- R3: Let k be the bit index of the dividend's highest set bit. With a nonzero dividend and divisor, `done` rises exactly 1 + (k + 1) clock edges after the edge that accepts `start`. `done` is high for one cycle only.
- R4: A zero dividend with a nonzero divisor completes 1 edge after the accepting edge, with `quotient` and `remainder` both zero and `div_zero` low.
- R5: A zero divisor completes 1 edge after the accepting edge. It sets `div_zero` to 1, `quotient` to all ones and `remainder` to the dividend. This holds even when the dividend is zero.
- R6: `start` is accepted only while `busy` is low. `start` pulses and operand changes while `busy` is high do not affect the result.
- R7: `quotient`, `remainder` and `div_zero` keep their values from the `done` cycle until the next accepted start.
- R8: `busy` is high from the edge after acceptance until the edge that raises `done`, and it is low in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division (used only while idle) |
| dividend | input | W | Numerator, sampled when start is accepted |
| divisor | input | W | Denominator, sampled when start is accepted |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Result quotient |
| remainder | output | W | Result remainder |
| div_zero | output | 1 | Divisor was zero |

## Verification
The bench first computes when each result is due. For a zero dividend or a zero divisor, the result is due 1 edge after acceptance. Otherwise it is due after 1 + (k + 1) edges, where k is the index of the dividend's highest set bit. The bench counts edges from the accepting edge and samples at each falling edge. It requires `done` to appear at exactly the predicted count, reads the results in that same half cycle, and checks one cycle later that `done` has dropped and the results have not moved.

// File: rtl/earlyin_div.sv
module earlyin_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_zero
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {S_IDLE, S_DETECT, S_ITER} state_t;
  state_t state;

  logic [W-1:0]  num, den, part, qacc;
  logic [CW-1:0] steps, lz;
  logic [W:0]    shifted, diff;
  logic          fits;

  always_comb begin
    lz = CW'(W);
    for (int i = 0; i < W; i++)
      if (num[i]) lz = CW'(W - 1 - i);
  end

  assign shifted = {part, num[W-1]};
  assign diff    = shifted - {1'b0, den};
  assign fits    = ~diff[W];
  assign busy    = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      num       <= '0;
      den       <= '0;
      part      <= '0;
      qacc      <= '0;
      steps     <= '0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          num      <= dividend;
          den      <= divisor;
          div_zero <= 1'b0;
          state    <= S_DETECT;
        end
        S_DETECT: begin
          if (den == '0) begin
            quotient  <= '1;
            remainder <= num;
            div_zero  <= 1'b1;
            done      <= 1'b1;
            state     <= S_IDLE;
          end else if (num == '0) begin
            quotient  <= '0;
            remainder <= '0;
            done      <= 1'b1;
            state     <= S_IDLE;
          end else begin
            num   <= num << lz;
            steps <= CW'(W) - lz;
            part  <= '0;
            qacc  <= '0;
            state <= S_ITER;
          end
        end
        S_ITER: begin
          num   <= num << 1;
          part  <= fits ? diff[W-1:0] : shifted[W-1:0];
          qacc  <= {qacc[W-2:0], fits};
          steps <= steps - 1'b1;
          if (steps == CW'(1)) begin
            quotient  <= {qacc[W-2:0], fits};
            remainder <= fits ? diff[W-1:0] : shifted[W-1:0];
            done      <= 1'b1;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/earlyin_div_chk.sv
module earlyin_div_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_zero
);
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

  p_dz_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (quotient == {W{1'b1}}));

  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind earlyin_div earlyin_div_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
);

// File: tb/earlyin_div_test.sv
module earlyin_div_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic         busy, done, div_zero;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int errors = 0;
  bit hung = 1'b0;

  always #10 clk = ~clk;

  earlyin_div #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input int a, input int b, input bit poke);
    int k, lat, eq, er;
    int top;
    logic [W-1:0] hq, hr;
    top = -1;
    for (int i = 0; i < W; i++) if (a[i]) top = i;
    lat = (a == 0 || b == 0) ? 1 : 1 + top + 1;
    if (b == 0) begin eq = (1 << W) - 1; er = a; end
    else begin eq = a / b; er = a % b; end
    dividend = W'(a); divisor = W'(b); start = 1'b1;
    @(negedge clk);
    start = poke;
    if (poke) begin dividend = ~W'(a); divisor = W'(b + 3); end
    k = 0;
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    while (!done && k < 64) begin
      @(negedge clk);
      start = 1'b0;
      k++;
    end
    start = 1'b0;
    if (k >= 64) begin hung = 1'b1; chk(1'b0, "R3 done timeout", k, lat); return; end
    if (b == 0) chk(k == lat, "R5 latency", k, lat);
    else if (a == 0) chk(k == lat, "R4 latency", k, lat);
    else chk(k == lat, "R3 latency", k, lat);
    chk(busy == 1'b0, "R8 busy low with done", busy, 0);
    if (b == 0) begin
      chk(div_zero == 1'b1, "R5 flag", div_zero, 1);
      chk(quotient == W'(eq), "R5 quotient", quotient, eq);
      chk(remainder == W'(er), "R5 remainder", remainder, er);
    end else begin
      chk(div_zero == 1'b0, "R2 flag low", div_zero, 0);
      chk(quotient == W'(eq), poke ? "R6 quotient" : (a == 0 ? "R4 quotient" : "R2 quotient"), quotient, eq);
      chk(remainder == W'(er), poke ? "R6 remainder" : (a == 0 ? "R4 remainder" : "R2 remainder"), remainder, er);
    end
    hq = quotient; hr = remainder;
    dividend = 8'h5A; divisor = 8'h03;
    @(negedge clk);
    chk(done == 1'b0, "R3 done single pulse", done, 0);
    chk(quotient == hq && remainder == hr, "R7 outputs hold", quotient, hq);
  endtask

  initial begin
    int dv[16] = '{0, 1, 2, 3, 5, 7, 8, 15, 16, 31, 64, 100, 127, 128, 200, 255};
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && div_zero == 0, "R1 reset flags", {busy, done, div_zero}, 0);
    chk(quotient == 0 && remainder == 0, "R1 reset results", quotient, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int j = 0; j < 16; j++)
      for (int a = 0; a < 256; a++) begin
        if (!hung) run_op(a, dv[j], (a % 7) == 3);
      end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule